// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block supplies a guessed destination for register-indirect jumps in a core that runs several hardware threads. Its storage is a direct-mapped array of whole target addresses, each with a valid flag. The slot is picked by hashing the word-aligned jump address with a short record of recently resolved indirect-jump targets. A parameter chooses whether that record is one register shared by all threads or one register per thread, selected by the thread ID.

The fetch stage presents a jump address and thread ID on the lookup port. One cycle later it receives a hit flag and a target. When the jump resolves, the back end presents the jump address, thread ID and true target on the update port. The block writes the slot chosen by the history as it stood before this update, marks the slot valid, and then shifts two low target bits into the history.

Top module: `ijp_target_predictor`

## Requirements
- R1: Reset clears every valid flag and every history register. A lookup made before any update since reset reports no prediction, and the outputs read zero while reset is held.
- R2: The response to a lookup appears one clock after the lookup is presented. In a cycle after one with no lookup, `predValid` is 0 and `predTarget` is 0.
- R3: The slot index is `pc[11:2] XOR history`, the history being the 10-bit register that belongs to the looking-up thread. Two identical lookups in a row, with no update in the first of the two cycles, return the same response.
- R4: An update writes the full target into the slot given by `updPc[11:2] XOR history`, using the history as it stood before this update, and marks the slot valid.
- R5: After each update, the selected history becomes `{old[7:0], updTarget[3:2]}`.
- R6: With `PER_THREAD_HIST=1` there are `NUM_THREADS` history registers. An update changes only the history of `updTid`.
- R7: With `PER_THREAD_HIST=0` one history register serves all threads. Every update shifts it, whatever thread ID it carries.
- R8: A lookup and an update in the same cycle that map to the same slot return the slot's contents from before the update.
- R9: A hit returns all 32 bits of the stored target. A miss returns a target of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookupEn | input | 1 | Lookup request |
| lookupPc | input | 32 | Address of the jump being looked up |
| lookupTid | input | 2 | Thread issuing the lookup |
| updEn | input | 1 | Update request from the resolved jump |
| updPc | input | 32 | Address of the resolved jump |
| updTid | input | 2 | Thread of the resolved jump |
| updTarget | input | 32 | Actual target of the resolved jump |
| predValid | output | 1 | Prediction hit, one cycle after lookup |
| predTarget | output | 32 | Predicted target, zero on a miss |

## Verification
Each lookup result is due exactly one clock edge after the lookup is presented. History and table changes from an update take effect for lookups presented from the next cycle on. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so every check reads the response to the row it drove. The same stream goes to a per-thread instance and a shared-history instance in parallel. Each row gives separate expected values for the two instances, worked out by hand from the index formula.

// File: rtl/ijp_pkg.sv
package ijp_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } ijp_strobe_t;

  localparam int ALIGN_BITS = 2;  // word alignment dropped from PCs
  localparam int SHIFT_BITS = 2;  // target bits pushed into history per update
endpackage

// File: rtl/ijp_ctrl.sv
module ijp_ctrl
  import ijp_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int IDX_W           = 10,
  parameter int HIST_W          = 10,
  parameter int NUM_THREADS     = 4,
  parameter bit PER_THREAD_HIST = 1'b1,
  localparam int TID_W          = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookupEn,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [TID_W-1:0]  lookupTid,
  input  logic              updEn,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [TID_W-1:0]  updTid,
  input  logic [ADDR_W-1:0] updTarget,
  output ijp_strobe_t       strobe,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx
);
  localparam int HIST_CNT = PER_THREAD_HIST ? NUM_THREADS : 1;

  logic [HIST_W-1:0] histQ [HIST_CNT];
  logic [HIST_W-1:0] lkHist;
  logic [HIST_W-1:0] upHist;
  logic [HIST_W-1:0] upHistNext;

  generate
    if (PER_THREAD_HIST) begin : g_sel_thread
      assign lkHist = histQ[lookupTid];
      assign upHist = histQ[updTid];
    end else begin : g_sel_shared
      assign lkHist = histQ[0];
      assign upHist = histQ[0];
    end
  endgenerate

  assign upHistNext = (upHist << SHIFT_BITS)
                    | HIST_W'(updTarget[ALIGN_BITS +: SHIFT_BITS]);

  generate
    for (genvar g = 0; g < HIST_CNT; g++) begin : g_hist
      logic mine;
      assign mine = (HIST_CNT == 1) ? 1'b1 : (updTid == TID_W'(g));
      always_ff @(posedge clk) begin
        if (rst) histQ[g] <= '0;
        else if (updEn && mine) histQ[g] <= upHistNext;
      end
    end
  endgenerate

  always_comb begin
    rdIdx       = lookupPc[ALIGN_BITS +: IDX_W] ^ IDX_W'(lkHist);
    wrIdx       = updPc[ALIGN_BITS +: IDX_W] ^ IDX_W'(upHist);
    strobe.rdEn = lookupEn;
    strobe.wrEn = updEn;
  end
endmodule

// File: rtl/ijp_datapath.sv
module ijp_datapath
  import ijp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  ijp_strobe_t       strobe,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrData,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget
);
  logic [ADDR_W-1:0] targetMem [DEPTH];
  logic [DEPTH-1:0]  validQ;
  logic              rdHit;

  assign rdHit = strobe.rdEn && validQ[rdIdx];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) targetMem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ     <= '0;
      predValid  <= 1'b0;
      predTarget <= '0;
    end else begin
      if (strobe.wrEn) validQ[wrIdx] <= 1'b1;
      predValid  <= rdHit;
      predTarget <= rdHit ? targetMem[rdIdx] : '0;
    end
  end
endmodule

// File: rtl/ijp_target_predictor.sv
module ijp_target_predictor
  import ijp_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int DEPTH           = 1024,
  parameter int HIST_W          = 10,
  parameter int NUM_THREADS     = 4,
  parameter bit PER_THREAD_HIST = 1'b1,
  localparam int IDX_W          = $clog2(DEPTH),
  localparam int TID_W          = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookupEn,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [TID_W-1:0]  lookupTid,
  input  logic              updEn,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [TID_W-1:0]  updTid,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget
);
  ijp_strobe_t      strobe;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;

  ijp_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W),
    .NUM_THREADS(NUM_THREADS), .PER_THREAD_HIST(PER_THREAD_HIST)
  ) ctrl (
    .clk(clk), .rst(rst),
    .lookupEn(lookupEn), .lookupPc(lookupPc), .lookupTid(lookupTid),
    .updEn(updEn), .updPc(updPc), .updTid(updTid), .updTarget(updTarget),
    .strobe(strobe), .rdIdx(rdIdx), .wrIdx(wrIdx)
  );

  ijp_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .wrData(updTarget),
    .predValid(predValid), .predTarget(predTarget)
  );
endmodule

// File: rtl/ijp_checker.sv
module ijp_checker #(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lookupEn,
  input logic [ADDR_W-1:0] lookupPc,
  input logic [TID_W-1:0]  lookupTid,
  input logic              updEn,
  input logic              predValid,
  input logic [ADDR_W-1:0] predTarget
);
  logic              seenUpd;
  logic              prevLk;
  logic              prevUpd;
  logic [ADDR_W-1:0] prevPc;
  logic [TID_W-1:0]  prevTid;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenUpd <= 1'b0;
      prevLk  <= 1'b0;
      prevUpd <= 1'b0;
      prevPc  <= '0;
      prevTid <= '0;
    end else begin
      if (updEn) seenUpd <= 1'b1;
      prevLk  <= lookupEn;
      prevUpd <= updEn;
      prevPc  <= lookupPc;
      prevTid <= lookupTid;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!predValid && predTarget == '0));

  assert_cold_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (lookupEn && !seenUpd) |=> !predValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lookupEn |=> (!predValid && predTarget == '0));

  assert_repeat_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (lookupEn && prevLk && !prevUpd && lookupPc == prevPc && lookupTid == prevTid)
    |=> (predValid == $past(predValid) && predTarget == $past(predTarget)));
endmodule

bind ijp_target_predictor ijp_checker #(.ADDR_W(ADDR_W), .TID_W(TID_W)) chk (
  .clk(clk), .rst(rst), .lookupEn(lookupEn), .lookupPc(lookupPc),
  .lookupTid(lookupTid), .updEn(updEn), .predValid(predValid),
  .predTarget(predTarget)
);

// File: tb/ijp_target_predictor_test.sv
`timescale 1ns/1ps
module ijp_target_predictor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookupEn = 1'b0;
  logic [31:0] lookupPc = '0;
  logic [1:0]  lookupTid = '0;
  logic        updEn = 1'b0;
  logic [31:0] updPc = '0;
  logic [1:0]  updTid = '0;
  logic [31:0] updTarget = '0;
  logic        pV, sV;
  logic [31:0] pT, sT;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ijp_target_predictor #(.PER_THREAD_HIST(1'b1)) uut (
    .clk(clk), .rst(rst), .lookupEn(lookupEn), .lookupPc(lookupPc),
    .lookupTid(lookupTid), .updEn(updEn), .updPc(updPc), .updTid(updTid),
    .updTarget(updTarget), .predValid(pV), .predTarget(pT));

  ijp_target_predictor #(.PER_THREAD_HIST(1'b0)) uutShared (
    .clk(clk), .rst(rst), .lookupEn(lookupEn), .lookupPc(lookupPc),
    .lookupTid(lookupTid), .updEn(updEn), .updPc(updPc), .updTid(updTid),
    .updTarget(updTarget), .predValid(sV), .predTarget(sT));

  typedef struct packed {
    logic        lk;  logic [31:0] lkPc; logic [1:0] lkTid;
    logic        up;  logic [31:0] upPc; logic [1:0] upTid; logic [31:0] upTgt;
    logic        pv;  logic [31:0] pt;
    logic        sv;  logic [31:0] st;
  } vec_t;

  localparam int NV = 13;
  // lk lkPc lkTid | up upPc upTid upTgt | per v,t | shared v,t
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h100, 2'd0, 1'b0, 32'h0,   2'd0, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0},
    '{1'b0, 32'h0,   2'd0, 1'b1, 32'h100, 2'd0, 32'h2004,     1'b0, 32'h0,        1'b0, 32'h0},
    '{1'b1, 32'h100, 2'd1, 1'b0, 32'h0,   2'd0, 32'h0,        1'b1, 32'h2004,     1'b0, 32'h0},
    '{1'b1, 32'h100, 2'd0, 1'b0, 32'h0,   2'd0, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0},
    '{1'b1, 32'h104, 2'd0, 1'b0, 32'h0,   2'd0, 32'h0,        1'b1, 32'h2004,     1'b1, 32'h2004},
    '{1'b0, 32'h0,   2'd0, 1'b1, 32'h200, 2'd2, 32'h3008,     1'b0, 32'h0,        1'b0, 32'h0},
    '{1'b1, 32'h200, 2'd2, 1'b0, 32'h0,   2'd0, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0},
    '{1'b1, 32'h208, 2'd2, 1'b0, 32'h0,   2'd0, 32'h0,        1'b1, 32'h3008,     1'b0, 32'h0},
    '{1'b1, 32'h21C, 2'd2, 1'b0, 32'h0,   2'd0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3008},
    '{1'b1, 32'h100, 2'd1, 1'b1, 32'h100, 2'd1, 32'hF0005000, 1'b1, 32'h2004,     1'b0, 32'h0},
    '{1'b1, 32'h100, 2'd1, 1'b0, 32'h0,   2'd0, 32'h0,        1'b1, 32'hF0005000, 1'b0, 32'h0},
    '{1'b0, 32'h104, 2'd0, 1'b0, 32'h0,   2'd0, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0},
    '{1'b1, 32'h104, 2'd0, 1'b0, 32'h0,   2'd0, 32'h0,        1'b1, 32'hF0005000, 1'b0, 32'h0}
  };
  localparam string TAGS [NV] = '{
    "R1 cold miss", "R2 idle output", "R6 R7 thread histories", "R5 shifted history",
    "R3 xor index", "R4 write with old history", "R5 history 10", "R6 thread two",
    "R7 shared history", "R8 same-cycle old data", "R4 overwrite",
    "R2 no lookup", "R9 full address"};

  task automatic check1(input logic av, input logic [31:0] at,
                        input logic ev, input logic [31:0] et, input string who,
                        input string tag);
    checks++;
    if (av !== ev || at !== et) begin
      fails++;
      $display("FAIL %s (%s): got valid=%0b target=%h, expected valid=%0b target=%h",
               tag, who, av, at, ev, et);
    end
  endtask

  task automatic step(input vec_t v, input string tag);
    lookupEn = v.lk; lookupPc = v.lkPc; lookupTid = v.lkTid;
    updEn = v.up; updPc = v.upPc; updTid = v.upTid; updTarget = v.upTgt;
    @(negedge clk);
    check1(pV, pT, v.pv, v.pt, "per-thread", tag);
    check1(sV, sT, v.sv, v.st, "shared", tag);
  endtask

  task automatic doReset();
    rst = 1'b1; lookupEn = 1'b0; updEn = 1'b0;
    repeat (2) @(negedge clk);
    check1(pV, pT, 1'b0, 32'h0, "per-thread", "R1 outputs in reset");
    check1(sV, sT, 1'b0, 32'h0, "shared", "R1 outputs in reset");
    rst = 1'b0;
  endtask

  initial begin
    doReset();
    for (int i = 0; i < NV; i++) step(VECS[i], TAGS[i]);

    // R1: reset in mid-run clears the valid flags that hold targets.
    @(negedge clk);
    doReset();
    step('{1'b1, 32'h100, 2'd1, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0},
         "R1 table cleared");
    step('{1'b1, 32'h104, 2'd0, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0},
         "R1 history cleared");

    // R5: two updates on thread 3 build history 0xE; both instances agree.
    step('{1'b0, 32'h0, 2'd0, 1'b1, 32'h0, 2'd3, 32'hC, 1'b0, 32'h0, 1'b0, 32'h0},
         "R5 first push");
    step('{1'b0, 32'h0, 2'd0, 1'b1, 32'h0, 2'd3, 32'h8, 1'b0, 32'h0, 1'b0, 32'h0},
         "R5 second push");
    step('{1'b1, 32'h38, 2'd3, 1'b0, 32'h0, 2'd0, 32'h0, 1'b1, 32'hC, 1'b1, 32'hC},
         "R5 history 0xE hits slot 0");
    step('{1'b1, 32'h34, 2'd3, 1'b0, 32'h0, 2'd0, 32'h0, 1'b1, 32'h8, 1'b1, 32'h8},
         "R4 slot 3 from history 3");
    step('{1'b1, 32'h0, 2'd3, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0},
         "R3 slot 0xE is empty");

    lookupEn = 1'b0; updEn = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule